// File: doc/BRIEF.md
# Nonvolatile Byte Store Register Controller

This block gives a small processor access to a 512-byte nonvolatile data store through four byte-wide I/O registers: two address registers, one data register and one control register. Software loads a 9-bit address and then sets the read-enable bit. The addressed byte appears in the data register, and the processor is held for four cycles. Writes are guarded by a two-step unlock. Software first sets the master-enable bit and then has four cycles to set the write-enable bit. That starts a self-timed programming cycle, and the processor is held for two cycles.

The write-enable bit stays at 1 while the byte is being programmed and clears itself when programming completes. Software can poll this bit or use the ready interrupt, which is a level request. The store is modelled as a byte RAM. The programming time is a cycle count set by a parameter, standing in for the multi-millisecond time of real cells.

Top module: `eep_regctl`

## Requirements
- R1: The address register at I/O offset 0x1F holds address bit 8 in bit 0 and reads 0 in bits 7..1. The register at offset 0x1E holds address bits 7..0. Together they select bytes 0 to 511 linearly.
- R2: The control register at offset 0x1C holds read enable in bit 0, write enable in bit 1, master enable in bit 2 and interrupt enable in bit 3. Bits 7..4 always read 0. The data register sits at offset 0x1D.
- R3: Writing 1 to read enable while no write is in progress loads the addressed byte into the data register and raises the stall output for exactly 4 cycles. Read enable reads 1 during those cycles and 0 afterwards.
- R4: A write starts when write enable is written to 1 within 4 clock cycles after master enable was set. Master enable clears itself by hardware 4 cycles after it was set.
- R5: Writing write enable to 1 without a valid master enable has no effect. This covers setting both bits in one access and setting write enable after the 4-cycle window. In each case write enable reads 0 and no stall occurs.
- R6: Starting a write raises the stall output for exactly 2 cycles. Write enable then reads 1 for WRITE_CYCLES cycles, clears by hardware, and the data byte is stored at the address.
- R7: A read request made while a write is in progress is ignored: no stall, and the data register is unchanged.
- R8: Writes to the address and data registers during a write in progress are blocked.
- R9: The ready interrupt output is 1 exactly when interrupt enable, the global interrupt flag input and NOT write enable are all true.
- R10: After reset, all four registers read 0, and the stall and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 6 | I/O register offset |
| ioWrEn | input | 1 | I/O write strobe |
| ioRdEn | input | 1 | I/O read strobe; read data is 0 when low |
| ioWdata | input | 8 | I/O write data |
| ioRdata | output | 8 | I/O read data, combinational from ioAddr |
| globalIntEn | input | 1 | Processor global interrupt flag |
| cpuStall | output | 1 | Processor hold request |
| readyIrq | output | 1 | Level ready interrupt request |

## Verification
The bench first goes after the edges of the unlock window. Write enable issued 3 idle cycles after master enable must start a write, while 4 idle cycles must not. A design with an off-by-one window counter fails one of these two cases. Exact stall lengths (4 for a read, 2 for a write) and the exact programming length are counted cycle by cycle, so any extra register stage in the timing shows up as a count mismatch. Reads, data writes and address writes issued during programming are checked at the ports. A design that lets them through returns a changed data byte or a changed address, or raises a stall it should not.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int IO_AW = 6;
  localparam logic [IO_AW-1:0] OFF_ADDR_HI = 6'h1F;
  localparam logic [IO_AW-1:0] OFF_ADDR_LO = 6'h1E;
  localparam logic [IO_AW-1:0] OFF_DATA    = 6'h1D;
  localparam logic [IO_AW-1:0] OFF_CTRL    = 6'h1C;

  // control-register bit positions
  localparam int BIT_RD  = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_MST = 2;
  localparam int BIT_IRQ = 3;

  typedef struct packed {
    logic ldAddrHi;
    logic ldAddrLo;
    logic ldData;
    logic rdLoad;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int WRITE_CYCLES = 40,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2,
  parameter int MST_WINDOW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             ioWrEn,
  input  logic [7:0]       ioWdata,
  input  logic             globalIntEn,
  output dpStrobe_t        strobe,
  output logic [7:0]       ctrlByte,
  output logic             wrBusy,
  output logic             cpuStall,
  output logic             readyIrq
);
  localparam int TW = $clog2(WRITE_CYCLES + 1);
  localparam int SW = $clog2(RD_STALL + WR_STALL + 1);
  localparam int MW = $clog2(MST_WINDOW + 1);

  logic          irqEn, masterEn, rdPend;
  logic [MW-1:0] winCnt;
  logic [TW-1:0] wrTimer;
  logic [SW-1:0] stallCnt;
  logic          ctrlSel, startWr, startRd, wrDone;

  assign ctrlSel = ioWrEn && (ioAddr == OFF_CTRL);
  assign startWr = ctrlSel && ioWdata[BIT_WR] && masterEn && !wrBusy;
  assign startRd = ctrlSel && ioWdata[BIT_RD] && !wrBusy && !startWr && !rdPend;
  assign wrDone  = wrBusy && (wrTimer == TW'(1));

  always_comb begin
    strobe.ldAddrHi = ioWrEn && (ioAddr == OFF_ADDR_HI) && !wrBusy;
    strobe.ldAddrLo = ioWrEn && (ioAddr == OFF_ADDR_LO) && !wrBusy;
    strobe.ldData   = ioWrEn && (ioAddr == OFF_DATA) && !wrBusy;
    strobe.rdLoad   = startRd;
    strobe.commit   = wrDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEn    <= 1'b0;
      masterEn <= 1'b0;
      winCnt   <= '0;
      wrBusy   <= 1'b0;
      wrTimer  <= '0;
      stallCnt <= '0;
      rdPend   <= 1'b0;
    end else begin
      if (ctrlSel) irqEn <= ioWdata[BIT_IRQ];

      if (startWr) begin
        masterEn <= 1'b0;
        winCnt   <= '0;
      end else if (ctrlSel && ioWdata[BIT_MST]) begin
        masterEn <= 1'b1;
        winCnt   <= MW'(MST_WINDOW);
      end else if (masterEn) begin
        if (winCnt == MW'(1)) masterEn <= 1'b0;
        winCnt <= winCnt - MW'(1);
      end

      if (startWr) begin
        wrBusy  <= 1'b1;
        wrTimer <= TW'(WRITE_CYCLES);
      end else if (wrDone) begin
        wrBusy  <= 1'b0;
        wrTimer <= '0;
      end else if (wrBusy) begin
        wrTimer <= wrTimer - TW'(1);
      end

      if (startWr)             stallCnt <= SW'(WR_STALL);
      else if (startRd)        stallCnt <= SW'(RD_STALL);
      else if (stallCnt != '0) stallCnt <= stallCnt - SW'(1);

      if (startRd)                                rdPend <= 1'b1;
      else if (rdPend && stallCnt == SW'(1))      rdPend <= 1'b0;
    end
  end

  assign cpuStall = (stallCnt != '0);
  assign readyIrq = irqEn && globalIntEn && !wrBusy;
  assign ctrlByte = {4'b0000, irqEn, masterEn, wrBusy, rdPend};

  AST_WR_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrBusy) |-> $past(masterEn)); // R4
  AST_WR_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrBusy) |-> cpuStall); // R6
  AST_RD_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdPend) |-> (cpuStall && !wrBusy)); // R3
  AST_RD_NOT_DURING_WR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdPend) |-> !$past(wrBusy)); // R7
endmodule

// File: rtl/eep_dp.sv
module eep_dp
  import eep_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [7:0]       ioWdata,
  input  logic [IO_AW-1:0] ioAddr,
  input  logic             ioRdEn,
  input  logic [7:0]       ctrlByte,
  input  logic             wrBusy,
  output logic [7:0]       ioRdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 8;

  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        dataReg;
  logic [7:0]        store [DEPTH];
  logic [7:0]        muxOut;

  always_ff @(posedge clk) begin
    if (strobe.commit) store[addrReg] <= dataReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.ldAddrHi) addrReg[ADDR_W-1:8] <= ioWdata[HI_W-1:0];
      if (strobe.ldAddrLo) addrReg[7:0]        <= ioWdata;
      if (strobe.ldData)      dataReg <= ioWdata;
      else if (strobe.rdLoad) dataReg <= store[addrReg];
    end
  end

  always_comb begin
    case (ioAddr)
      OFF_ADDR_HI: muxOut = 8'(addrReg[ADDR_W-1:8]);
      OFF_ADDR_LO: muxOut = addrReg[7:0];
      OFF_DATA:    muxOut = dataReg;
      OFF_CTRL:    muxOut = ctrlByte;
      default:     muxOut = 8'h00;
    endcase
    ioRdata = ioRdEn ? muxOut : 8'h00;
  end

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && $past(wrBusy)) |-> $stable(addrReg)); // R8
  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && $past(wrBusy)) |-> $stable(dataReg)); // R8
endmodule

// File: rtl/eep_regctl.sv
module eep_regctl
  import eep_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 40,
  parameter int RD_STALL     = 4,
  parameter int WR_STALL     = 2,
  parameter int MST_WINDOW   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [5:0] ioAddr,
  input  logic       ioWrEn,
  input  logic       ioRdEn,
  input  logic [7:0] ioWdata,
  output logic [7:0] ioRdata,
  input  logic       globalIntEn,
  output logic       cpuStall,
  output logic       readyIrq
);
  dpStrobe_t  strobe;
  logic [7:0] ctrlByte;
  logic       wrBusy;

  eep_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES), .RD_STALL(RD_STALL),
    .WR_STALL(WR_STALL), .MST_WINDOW(MST_WINDOW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioWdata(ioWdata), .globalIntEn(globalIntEn), .strobe(strobe),
    .ctrlByte(ctrlByte), .wrBusy(wrBusy), .cpuStall(cpuStall),
    .readyIrq(readyIrq)
  );

  eep_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ioWdata(ioWdata),
    .ioAddr(ioAddr), .ioRdEn(ioRdEn), .ctrlByte(ctrlByte),
    .wrBusy(wrBusy), .ioRdata(ioRdata)
  );
endmodule

// File: tb/eep_regctl_bench.sv
module eep_regctl_bench;
  localparam int WRITE_CYCLES = 40;
  localparam logic [5:0] A_HI = 6'h1F, A_LO = 6'h1E, A_DAT = 6'h1D, A_CTL = 6'h1C;

  logic clk = 0, rstN = 0, ioWrEn = 0, ioRdEn = 0, globalIntEn = 0;
  logic [5:0] ioAddr = '0;
  logic [7:0] ioWdata = '0, ioRdata;
  logic cpuStall, readyIrq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [512];
  logic       irqModel = 0;

  always #10 clk = ~clk;

  eep_regctl u_eep_regctl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn), .ioRdEn(ioRdEn),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .globalIntEn(globalIntEn),
    .cpuStall(cpuStall), .readyIrq(readyIrq)
  );

  function automatic logic [7:0] expCtrl(logic irq, logic mst, logic wr, logic rd);
    return {4'b0000, irq, mst, wr, rd};
  endfunction

  function automatic logic expIrq(logic irq, logic gie, logic wr);
    return irq & gie & ~wr;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic ioWrite(logic [5:0] a, logic [7:0] d);
    ioAddr = a; ioWdata = d; ioWrEn = 1; ioRdEn = 0;
    @(negedge clk);
    ioWrEn = 0;
    if (a == A_CTL) irqModel = d[3];
  endtask

  task automatic ioRead(logic [5:0] a, output logic [7:0] v);
    ioAddr = a; ioRdEn = 1; #1; v = ioRdata; ioRdEn = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setAddr(logic [8:0] a);
    ioWrite(A_HI, {7'b0, a[8]});
    ioWrite(A_LO, a[7:0]);
  endtask

  // full write; gap = idle cycles between unlock and write enable
  task automatic doWrite(logic [8:0] a, logic [7:0] d, int gap);
    logic [7:0] v;
    int n, stallN;
    logic irq;
    irq = 1'($urandom % 2);
    setAddr(a);
    ioWrite(A_DAT, d);
    ioWrite(A_CTL, {4'b0, irq, 3'b100});
    idle(gap);
    ioWrite(A_CTL, {4'b0, irq, 3'b010});
    n = 0; stallN = 0;
    ioRead(A_CTL, v);
    while (v[1] === 1'b1 && n < WRITE_CYCLES + 10) begin
      if (cpuStall) stallN++;
      check("R9 irq level during write", readyIrq, expIrq(irqModel, globalIntEn, 1'b1));
      n++;
      @(negedge clk);
      ioRead(A_CTL, v);
    end
    check("R4/R6 write busy length", n, WRITE_CYCLES);
    check("R6 write stall length", stallN, 2);
    check("R4 master cleared after write", v, expCtrl(irqModel, 0, 0, 0));
    check("R9 irq level after write", readyIrq, expIrq(irqModel, globalIntEn, 1'b0));
    model[a] = d;
  endtask

  task automatic doRead(logic [8:0] a);
    logic [7:0] v;
    int n;
    setAddr(a);
    ioWrite(A_CTL, 8'h01);
    ioRead(A_CTL, v);
    check("R3 read enable set during read", v, expCtrl(0, 0, 0, 1));
    n = 0;
    while (cpuStall === 1'b1 && n < 20) begin n++; @(negedge clk); end
    check("R3 read stall length", n, 4);
    ioRead(A_CTL, v);
    check("R3 read enable self-clears", v, expCtrl(0, 0, 0, 0));
    ioRead(A_DAT, v);
    check("R3 read data", v, model[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [8:0] addrs [24];
    void'($urandom(32'd20251));
    idle(3);
    rstN = 1;
    @(negedge clk);

    // R10 reset state
    ioRead(A_HI, v);  check("R10 reset addr hi", v, 0);
    ioRead(A_LO, v);  check("R10 reset addr lo", v, 0);
    ioRead(A_DAT, v); check("R10 reset data", v, 0);
    ioRead(A_CTL, v); check("R10 reset ctrl", v, 0);
    check("R10 reset stall", cpuStall, 0);
    globalIntEn = 1;
    #1 check("R10 reset irq", readyIrq, 0);

    // R1 address split, R2 reserved bits
    ioWrite(A_HI, 8'hFF);
    ioRead(A_HI, v); check("R1 addr hi upper bits zero", v, 8'h01);
    ioWrite(A_LO, 8'hA5);
    ioRead(A_LO, v); check("R1 addr lo", v, 8'hA5);
    ioWrite(A_CTL, 8'hF8);
    ioRead(A_CTL, v); check("R2 reserved bits read zero", v, 8'h08);
    check("R9 irq with enable and gie", readyIrq, 1);
    globalIntEn = 0; #1;
    check("R9 irq gated by gie", readyIrq, 0);
    globalIntEn = 1;

    // R4 master enable self-clears after 4 cycles
    ioWrite(A_CTL, 8'h04);
    ioRead(A_CTL, v); check("R4 master set", v, expCtrl(0, 1, 0, 0));
    idle(3);
    ioRead(A_CTL, v); check("R4 master still set at cycle 4", v, expCtrl(0, 1, 0, 0));
    idle(1);
    ioRead(A_CTL, v); check("R4 master cleared", v, expCtrl(0, 0, 0, 0));

    // R5 write enable after window: no effect
    ioWrite(A_CTL, 8'h04);
    idle(4);
    ioWrite(A_CTL, 8'h02);
    check("R5 late write enable no stall", cpuStall, 0);
    ioRead(A_CTL, v); check("R5 late write enable ignored", v, expCtrl(0, 0, 0, 0));
    // R5 both bits in one access
    ioWrite(A_CTL, 8'h06);
    check("R5 combined access no stall", cpuStall, 0);
    ioRead(A_CTL, v); check("R5 combined access no write", v[1], 0);
    idle(5);
    // R5 write enable alone
    ioWrite(A_CTL, 8'h02);
    ioRead(A_CTL, v); check("R5 write enable alone ignored", v, expCtrl(0, 0, 0, 0));

    // directed window edges and extreme addresses
    doWrite(9'd0, 8'h3C, 0);
    doWrite(9'd511, 8'hC3, 3);
    doWrite(9'd256, 8'h81, 1);
    doRead(9'd511); doRead(9'd0); doRead(9'd256);

    // random writes then readbacks
    for (int i = 0; i < 24; i++) begin
      addrs[i] = 9'($urandom % 512);
      globalIntEn = 1'($urandom % 2);
      doWrite(addrs[i], 8'($urandom), int'($urandom % 4));
    end
    for (int i = 0; i < 24; i++) doRead(addrs[i]);

    // R7/R8 accesses blocked during programming
    setAddr(9'h123);
    ioWrite(A_DAT, 8'h77);
    ioWrite(A_CTL, 8'h04);
    ioWrite(A_CTL, 8'h02);
    idle(2);
    ioWrite(A_DAT, 8'h5A);
    ioWrite(A_LO, 8'h00);
    ioWrite(A_HI, 8'h00);
    ioWrite(A_CTL, 8'h01);
    check("R7 read during write no stall", cpuStall, 0);
    ioRead(A_CTL, v); check("R7 read enable not set", v[0], 0);
    ioRead(A_DAT, v); check("R8 data write blocked", v, 8'h77);
    ioRead(A_LO, v);  check("R8 addr lo blocked", v, 8'h23);
    ioRead(A_HI, v);  check("R8 addr hi blocked", v, 8'h01);
    ioRead(A_CTL, v);
    while (v[1] === 1'b1) begin @(negedge clk); ioRead(A_CTL, v); end
    model[9'h123] = 8'h77;
    doRead(9'h123);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule